// File: doc/BRIEF.md
# Interleaved DRAM Page-Mode Read Sequencer

This block turns cache-line read requests into DRAM strobe sequences and returns each line as four back-to-back data beats. The array is either one bank or two interleaved banks. The `cfg_interleave` input selects the organisation and is changed only while reset is held. The block remembers which row is open in each bank. It sorts every read into one of three cases: a page hit, a miss on a bank with no open row, or a miss that must first close another row. Each case has a fixed first-beat latency, and the block times its strobes to meet it.

Requests enter through a valid/ready port and wait in a small in-order queue. One line is in service at a time, and the next one starts in the cycle right after the previous line's last beat. Row and column widths are parameters and may differ by up to two bits; the default is 12 row bits and 10 column bits. The data path carries 64 bits per beat, or 72 when the `ECC_EN` parameter adds the check-bit lanes. The block only passes those lanes through and does no ECC work.

Top module: `dram_rdseq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `req_ready` is 1, `rd_valid` is 0, and both bits of `dram_ras_n` and `dram_cas_n` are 1.
- R2: A read to a bank with no open row is reported with `rd_kind` = 1. When the block is idle, its first beat is present 11 rising edges after the acceptance edge. From the first cycle of service, `dram_ras_n[bank]` is low and `dram_addr` carries the row.
- R3: A read whose row equals the bank's open row is reported with `rd_kind` = 0. When the block is idle, its first beat is present 8 edges after acceptance.
- R4: A read to a bank with a different open row is reported with `rd_kind` = 2. When the block is idle, its first beat is present 14 edges after acceptance. `dram_ras_n[bank]` is high for the first three service cycles, and the new row then appears on `dram_addr` with RAS low.
- R5: Each line returns exactly four beats in consecutive cycles. `rd_beat` counts 0,1,2,3. `rd_line` echoes the accepted address, and `rd_data` equals `dram_dq` as it stood at the preceding rising edge.
- R6: In interleaved mode, line-address bit 0 selects the bank, bits [8:1] the line column and bits [20:9] the row (default widths). Each bank keeps its own open row, so traffic to one bank never changes the classification of the other.
- R7: In single-bank mode, bits [7:0] are the line column, bits [19:8] the row, and bit 20 is ignored. Bank 1 strobes (`dram_ras_n[1]`, `dram_cas_n[1]`) stay high.
- R8: For each beat, `dram_cas_n[bank]` is low exactly 3 cycles before that beat, while `dram_addr` = {line column, beat index}. CAS is never low on a bank whose RAS is high, and at most one CAS bit is low at a time.
- R9: Up to four accepted lines wait beyond the one in service. With five lines held, `req_ready` is 0. Lines return in acceptance order.
- R10: Reset forgets all open rows, so the first read to each bank afterwards is a miss without precharge.
- R11: A queued line begins service in the cycle right after the previous line's last beat. A queued hit therefore delivers its first beat 8 cycles after that last beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_interleave | input | 1 | 1: two interleaved banks, 0: single bank |
| req_valid | input | 1 | Read request present |
| req_addr | input | ROW_W+COL_W-1 | Cache-line address |
| req_ready | output | 1 | Queue can take a request |
| rd_valid | output | 1 | Data beat present |
| rd_beat | output | 2 | Beat index within the line |
| rd_kind | output | 2 | Page case of the line: 0 hit, 1 idle miss, 2 precharge miss |
| rd_line | output | ROW_W+COL_W-1 | Address of the line being returned |
| rd_data | output | DATA_W(+DATA_W/8) | Beat data, zero when no beat |
| dram_ras_n | output | 2 | Row strobe per bank, active low |
| dram_cas_n | output | 2 | Column strobe per bank, active low |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_dq | input | DATA_W(+DATA_W/8) | Read data from the array |

## Verification
With the block idle, the timing is counted in rising edges after the acceptance edge. The row address is due after 1 edge for an idle miss and after 4 for a precharge miss. The first CAS is due 3 edges before the first beat. The first beat is due after 8, 11 or 14 edges, and the last beat 3 edges after the first. The bench samples on falling edges and indexes each sample by the edges since acceptance, so every result is read in exactly the cycle it is due. It also checks that no beat appears earlier and that none follows the fourth. For queued traffic, the bench times each line from the previous line's last beat rather than from its own acceptance.

// File: rtl/dram_rdseq_pkg.sv
package dram_rdseq_pkg;

  // page case of one line; code values are visible on rd_kind
  typedef enum logic [1:0] {
    PG_HIT   = 2'd0,
    PG_IDLE  = 2'd1,
    PG_PRECH = 2'd2
  } page_kind_e;

  // service-cycle index (0 = first cycle after the start edge) of beat 0
  function automatic int first_beat_k(page_kind_e kd, int hit_l, int idle_l, int pre_l);
    case (kd)
      PG_HIT:  return hit_l - 1;
      PG_IDLE: return idle_l - 1;
      default: return pre_l - 1;
    endcase
  endfunction

  // service-cycle index at which the row is activated
  function automatic int act_start_k(page_kind_e kd, int pre_gap);
    return (kd == PG_PRECH) ? pre_gap : 0;
  endfunction

endpackage

// File: rtl/rdseq_fifo.sv
module rdseq_fifo #(
  parameter int W     = 21,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic [LW-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      if (push && !pop)      level <= level + 1'b1;
      else if (pop && !push) level <= level - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  assign dout  = mem[rp];
  assign empty = (level == '0);
endmodule

// File: rtl/rdseq_bank_track.sv
module rdseq_bank_track
  import dram_rdseq_pkg::*;
#(
  parameter int ROW_W = 12,
  parameter int NBANK = 2,
  localparam int BW   = $clog2(NBANK)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BW-1:0]    look_bank,
  input  logic [ROW_W-1:0] look_row,
  input  logic             upd,
  output page_kind_e       kind,
  output logic [NBANK-1:0] open_valid
);
  logic [ROW_W-1:0] row_v [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [ROW_W-1:0] row_r;
    always_ff @(posedge clk) begin
      if (rst) begin
        open_valid[b] <= 1'b0;
        row_r         <= '0;
      end else if (upd && look_bank == BW'(b)) begin
        open_valid[b] <= 1'b1;
        row_r         <= look_row;
      end
    end
    assign row_v[b] = row_r;
  end

  always_comb begin
    if (!open_valid[look_bank])            kind = PG_IDLE;
    else if (row_v[look_bank] == look_row) kind = PG_HIT;
    else                                   kind = PG_PRECH;
  end
endmodule

// File: rtl/rdseq_timer.sv
module rdseq_timer
  import dram_rdseq_pkg::*;
#(
  parameter int ROW_W    = 12,
  parameter int COL_W    = 10,
  parameter int ADDR_W   = 21,
  parameter int MA_W     = 12,
  parameter int HIT_LAT  = 8,
  parameter int IDLE_LAT = 11,
  parameter int PRE_LAT  = 14,
  parameter int CAS_LAT  = 3,
  localparam int CL_W    = COL_W - 2,
  localparam int KW      = $clog2(PRE_LAT + 4),
  localparam int ACT_GAP = IDLE_LAT - HIT_LAT,
  localparam int PRE_GAP = PRE_LAT - IDLE_LAT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  page_kind_e        kind_in,
  input  logic              bank_in,
  input  logic [ROW_W-1:0]  row_in,
  input  logic [CL_W-1:0]   col_in,
  input  logic [ADDR_W-1:0] line_in,
  output logic              can_start,
  output logic              beat_valid,
  output logic [1:0]        beat_idx,
  output page_kind_e        kind_q,
  output logic [ADDR_W-1:0] line_q,
  output logic              bank_q,
  output logic              prech_hold,
  output logic              act_win,
  output logic [1:0]        cas_n,
  output logic [MA_W-1:0]   dram_addr
);
  logic             active;
  logic [KW-1:0]    k;
  logic [ROW_W-1:0] row_q;
  logic [CL_W-1:0]  col_q;
  logic             last, cas_win;
  logic [1:0]       cidx;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      k      <= '0;
      kind_q <= PG_HIT;
      bank_q <= 1'b0;
      row_q  <= '0;
      col_q  <= '0;
      line_q <= '0;
    end else if (start) begin
      active <= 1'b1;
      k      <= '0;
      kind_q <= kind_in;
      bank_q <= bank_in;
      row_q  <= row_in;
      col_q  <= col_in;
      line_q <= line_in;
    end else if (last) begin
      active <= 1'b0;
    end else if (active) begin
      k <= k + 1'b1;
    end
  end

  always_comb begin
    int kk, fb, ra, cs;
    kk = int'(k);
    fb = first_beat_k(kind_q, HIT_LAT, IDLE_LAT, PRE_LAT);
    ra = act_start_k(kind_q, PRE_GAP);
    cs = fb - CAS_LAT;
    act_win    = active && (kind_q != PG_HIT) && kk >= ra && kk < ra + ACT_GAP;
    prech_hold = active && (kind_q == PG_PRECH) && kk < PRE_GAP;
    cas_win    = active && kk >= cs && kk < cs + 4;
    beat_valid = active && kk >= fb && kk < fb + 4;
    last       = active && kk == fb + 3;
    beat_idx   = beat_valid ? 2'(kk - fb) : 2'd0;
    cidx       = 2'(kk - cs);
  end

  always_comb begin
    cas_n = 2'b11;
    if (cas_win) cas_n[bank_q] = 1'b0;
    if (act_win)      dram_addr = MA_W'(row_q);
    else if (cas_win) dram_addr = MA_W'({col_q, cidx});
    else              dram_addr = '0;
  end

  assign can_start = !active || last;
endmodule

// File: rtl/dram_rdseq.sv
module dram_rdseq
  import dram_rdseq_pkg::*;
#(
  parameter int ROW_W    = 12,
  parameter int COL_W    = 10,
  parameter int DATA_W   = 64,
  parameter bit ECC_EN   = 1'b0,
  parameter int QDEPTH   = 4,
  parameter int HIT_LAT  = 8,
  parameter int IDLE_LAT = 11,
  parameter int PRE_LAT  = 14,
  parameter int CAS_LAT  = 3
) (
  input  logic                                        clk,
  input  logic                                        rst,
  input  logic                                        cfg_interleave,
  input  logic                                        req_valid,
  input  logic [ROW_W+COL_W-2:0]                      req_addr,
  output logic                                        req_ready,
  output logic                                        rd_valid,
  output logic [1:0]                                  rd_beat,
  output logic [1:0]                                  rd_kind,
  output logic [ROW_W+COL_W-2:0]                      rd_line,
  output logic [DATA_W+(ECC_EN ? DATA_W/8 : 0)-1:0]   rd_data,
  output logic [1:0]                                  dram_ras_n,
  output logic [1:0]                                  dram_cas_n,
  output logic [(ROW_W > COL_W ? ROW_W : COL_W)-1:0]  dram_addr,
  input  logic [DATA_W+(ECC_EN ? DATA_W/8 : 0)-1:0]   dram_dq
);
  localparam int ADDR_W = ROW_W + COL_W - 1;
  localparam int CL_W   = COL_W - 2;
  localparam int BUS_W  = DATA_W + (ECC_EN ? DATA_W / 8 : 0);
  localparam int MA_W   = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int LW     = $clog2(QDEPTH + 1);
  localparam int NBANK  = 2;

  // address split, chosen by organisation
  function automatic logic bank_of(input logic il, input logic [ADDR_W-1:0] a);
    return il ? a[0] : 1'b0;
  endfunction
  function automatic logic [CL_W-1:0] col_of(input logic il, input logic [ADDR_W-1:0] a);
    return il ? a[CL_W:1] : a[CL_W-1:0];
  endfunction
  function automatic logic [ROW_W-1:0] row_of(input logic il, input logic [ADDR_W-1:0] a);
    return il ? a[ADDR_W-1:CL_W+1] : a[ADDR_W-2:CL_W];
  endfunction

  logic [ADDR_W-1:0] head;
  logic              q_empty;
  logic [LW-1:0]     fifo_level;
  logic              seq_start;
  logic              can_start;
  logic              push;
  page_kind_e        head_kind, kind_q;
  logic [NBANK-1:0]  open_valid;
  logic              bank_q, prech_hold, act_win;
  logic [BUS_W-1:0]  data_q;

  assign req_ready = (fifo_level < LW'(QDEPTH));
  assign push      = req_valid && req_ready;
  assign seq_start = !q_empty && can_start;

  rdseq_fifo #(.W(ADDR_W), .DEPTH(QDEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .din(req_addr), .pop(seq_start),
    .dout(head), .empty(q_empty), .level(fifo_level)
  );

  rdseq_bank_track #(.ROW_W(ROW_W), .NBANK(NBANK)) u_track (
    .clk(clk), .rst(rst),
    .look_bank(bank_of(cfg_interleave, head)),
    .look_row(row_of(cfg_interleave, head)),
    .upd(seq_start), .kind(head_kind), .open_valid(open_valid)
  );

  rdseq_timer #(
    .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .MA_W(MA_W),
    .HIT_LAT(HIT_LAT), .IDLE_LAT(IDLE_LAT), .PRE_LAT(PRE_LAT), .CAS_LAT(CAS_LAT)
  ) u_timer (
    .clk(clk), .rst(rst), .start(seq_start), .kind_in(head_kind),
    .bank_in(bank_of(cfg_interleave, head)),
    .row_in(row_of(cfg_interleave, head)),
    .col_in(col_of(cfg_interleave, head)),
    .line_in(head), .can_start(can_start),
    .beat_valid(rd_valid), .beat_idx(rd_beat), .kind_q(kind_q),
    .line_q(rd_line), .bank_q(bank_q), .prech_hold(prech_hold),
    .act_win(act_win), .cas_n(dram_cas_n), .dram_addr(dram_addr)
  );

  // a bank's row strobe stays low while its page is open, except during precharge
  for (genvar b = 0; b < NBANK; b++) begin : g_ras
    assign dram_ras_n[b] = !open_valid[b] || (prech_hold && bank_q == 1'(b));
  end

  always_ff @(posedge clk) begin
    if (rst) data_q <= '0;
    else     data_q <= dram_dq;
  end

  assign rd_data = rd_valid ? data_q : '0;
  assign rd_kind = kind_q;
endmodule

// File: rtl/dram_rdseq_chk.sv
module dram_rdseq_chk
  import dram_rdseq_pkg::*;
#(
  parameter int QDEPTH   = 4,
  parameter int HIT_LAT  = 8,
  parameter int IDLE_LAT = 11,
  parameter int PRE_LAT  = 14,
  localparam int LW      = $clog2(QDEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_interleave,
  input logic          seq_start,
  input logic          act_win,
  input logic [LW-1:0] fifo_level,
  input logic          rd_valid,
  input logic [1:0]    rd_beat,
  input logic [1:0]    rd_kind,
  input logic [1:0]    dram_ras_n,
  input logic [1:0]    dram_cas_n
);
  logic [7:0] since;
  always_ff @(posedge clk) begin
    if (rst)            since <= 8'hff;
    else if (seq_start) since <= 8'd0;
    else if (since != 8'hff) since <= since + 8'd1;
  end

  // R5
  beat_seq_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid && rd_beat != 2'd3 |=> rd_valid && rd_beat == $past(rd_beat) + 2'd1);
  // R5
  burst_end_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid && rd_beat == 2'd3 |=> !rd_valid);
  // R2 R3 R4
  first_beat_lat_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid && rd_beat == 2'd0 |->
      int'(since) == first_beat_k(page_kind_e'(rd_kind), HIT_LAT, IDLE_LAT, PRE_LAT));
  // R8
  cas0_ras_chk: assert property (@(posedge clk) disable iff (rst)
    !dram_cas_n[0] |-> !dram_ras_n[0]);
  // R8
  cas1_ras_chk: assert property (@(posedge clk) disable iff (rst)
    !dram_cas_n[1] |-> !dram_ras_n[1]);
  // R8
  cas_single_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(~dram_cas_n) <= 1);
  // R2 R4
  act_no_cas_chk: assert property (@(posedge clk) disable iff (rst)
    act_win |-> dram_cas_n == 2'b11);
  // R7
  single_bank_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_interleave |-> dram_ras_n[1] && dram_cas_n[1]);
  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    int'(fifo_level) <= QDEPTH);
endmodule

bind dram_rdseq dram_rdseq_chk #(
  .QDEPTH(QDEPTH), .HIT_LAT(HIT_LAT), .IDLE_LAT(IDLE_LAT), .PRE_LAT(PRE_LAT)
) u_chk (
  .clk(clk), .rst(rst), .cfg_interleave(cfg_interleave), .seq_start(seq_start),
  .act_win(act_win), .fifo_level(fifo_level), .rd_valid(rd_valid),
  .rd_beat(rd_beat), .rd_kind(rd_kind), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n)
);

// File: tb/dram_rdseq_test.sv
module dram_rdseq_test;
  localparam int AW = 21;
  localparam int BW = 64;
  localparam int K_HIT = 0, K_IDLE = 1, K_PRE = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_interleave = 1'b1;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_ready, rd_valid;
  logic [1:0]    rd_beat, rd_kind, dram_ras_n, dram_cas_n;
  logic [AW-1:0] rd_line;
  logic [BW-1:0] rd_data, dram_dq;
  logic [11:0]   dram_addr;
  longint        cyc = 0;
  int            total = 0, fails = 0;
  bit            done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign dram_dq = BW'(cyc);

  dram_rdseq uut (
    .clk(clk), .rst(rst), .cfg_interleave(cfg_interleave), .req_valid(req_valid),
    .req_addr(req_addr), .req_ready(req_ready), .rd_valid(rd_valid), .rd_beat(rd_beat),
    .rd_kind(rd_kind), .rd_line(rd_line), .rd_data(rd_data), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_addr(dram_addr), .dram_dq(dram_dq)
  );

  function automatic logic [AW-1:0] il(input logic [11:0] row, input logic [7:0] col, input logic b);
    return {row, col, b};
  endfunction
  function automatic logic [AW-1:0] sb(input logic top, input logic [11:0] row, input logic [7:0] col);
    return {top, row, col};
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic il_mode);
    @(negedge clk);
    rst = 1'b1;
    cfg_interleave = il_mode;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic issue(input logic [AW-1:0] a);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // one line with the block idle; j counts rising edges since acceptance
  task automatic run_line(input logic [AW-1:0] a, input int bank, input logic [11:0] row,
                          input logic [7:0] col, input int kind, input int lat, input string tag);
    int ra, early, bad, first_ok;
    ra = (kind == K_PRE) ? 3 : 0;
    early = 0; bad = 0; first_ok = 0;
    issue(a);
    for (int j = 1; j <= lat + 4; j++) begin
      @(negedge clk);
      if (j < lat && rd_valid) early++;
      if (kind == K_PRE && j == 1)
        chk(dram_ras_n[bank] == 1'b1, "R4", "ras high in precharge", dram_ras_n[bank], 1);
      if (kind != K_HIT && j == 1 + ra) begin
        chk(dram_addr == row && dram_ras_n[bank] == 1'b0, tag, "row on addr with ras low",
            {dram_ras_n[bank], dram_addr}, {1'b0, row});
      end
      if (j == lat - 3)
        chk(dram_cas_n[bank] == 1'b0 && dram_addr == 12'({col, 2'b00}), "R8", "first cas",
            {dram_cas_n, dram_addr}, 12'({col, 2'b00}));
      if (j == lat) first_ok = rd_valid;
      if (j >= lat && j < lat + 4) begin
        if (!(rd_valid && rd_beat == 2'(j - lat) && int'(rd_kind) == kind &&
              rd_line == a && rd_data == BW'(cyc - 1))) bad++;
      end
      if (j == lat + 4) chk(!rd_valid, "R5", "no fifth beat", rd_valid, 0);
    end
    chk(first_ok == 1 && early == 0, tag, "first beat latency", early, lat);
    chk(bad == 0, "R5", "burst beats/kind/line/data", bad, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
    chk(rd_valid == 1'b0, "R1", "no beat in reset", rd_valid, 0);
    chk(dram_ras_n == 2'b11 && dram_cas_n == 2'b11, "R1", "strobes idle", {dram_ras_n, dram_cas_n}, 4'hf);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !rd_valid && dram_ras_n == 2'b11, "R1", "state after reset",
        {req_ready, rd_valid, dram_ras_n}, 4'b1011);
  endtask

  task automatic t_interleave();
    do_reset(1'b1);
    run_line(il(12'h155, 8'h21, 1'b0), 0, 12'h155, 8'h21, K_IDLE, 11, "R2");
    run_line(il(12'h155, 8'h40, 1'b0), 0, 12'h155, 8'h40, K_HIT, 8, "R3");
    run_line(il(12'haaa, 8'h05, 1'b1), 1, 12'haaa, 8'h05, K_IDLE, 11, "R6");
    chk(dram_ras_n == 2'b00, "R6", "both banks open", dram_ras_n, 0);
    run_line(il(12'h155, 8'h7f, 1'b0), 0, 12'h155, 8'h7f, K_HIT, 8, "R6");
    run_line(il(12'h3c3, 8'h02, 1'b0), 0, 12'h3c3, 8'h02, K_PRE, 14, "R4");
    run_line(il(12'haaa, 8'h06, 1'b1), 1, 12'haaa, 8'h06, K_HIT, 8, "R6");
  endtask

  task automatic t_reset_clears();
    do_reset(1'b1);
    run_line(il(12'h3c3, 8'h09, 1'b0), 0, 12'h3c3, 8'h09, K_IDLE, 11, "R10");
    run_line(il(12'haaa, 8'h09, 1'b1), 1, 12'haaa, 8'h09, K_IDLE, 11, "R10");
  endtask

  task automatic t_single();
    do_reset(1'b0);
    run_line(sb(1'b0, 12'h0f0, 8'h10), 0, 12'h0f0, 8'h10, K_IDLE, 11, "R7");
    run_line(sb(1'b0, 12'h0f0, 8'h11), 0, 12'h0f0, 8'h11, K_HIT, 8, "R7");
    run_line(sb(1'b1, 12'h0f0, 8'h12), 0, 12'h0f0, 8'h12, K_HIT, 8, "R7");
    chk(dram_ras_n[1] == 1'b1, "R7", "bank1 ras idle", dram_ras_n[1], 1);
    run_line(sb(1'b0, 12'h801, 8'h12), 0, 12'h801, 8'h12, K_PRE, 14, "R7");
  endtask

  task automatic t_queue();
    logic [AW-1:0] q [6];
    logic [AW-1:0] got_line [24];
    logic [1:0]    got_beat [24];
    longint        got_t [24];
    int stall_at, bad;
    for (int i = 0; i < 6; i++) q[i] = il(12'h111, 8'(8'h30 + i), 1'b0);
    stall_at = -1;
    do_reset(1'b1);
    fork
      begin
        for (int i = 0; i < 6; i++) begin
          @(negedge clk);
          while (!req_ready) begin
            if (stall_at < 0) stall_at = i;
            @(negedge clk);
          end
          req_valid = 1'b1;
          req_addr  = q[i];
          @(posedge clk);
        end
        @(negedge clk);
        req_valid = 1'b0;
      end
      begin
        int n;
        n = 0;
        while (n < 24) begin
          @(negedge clk);
          if (rd_valid) begin
            got_line[n] = rd_line;
            got_beat[n] = rd_beat;
            got_t[n]    = cyc;
            n++;
          end
        end
      end
    join
    chk(stall_at == 5, "R9", "ready drops with five lines held", stall_at, 5);
    bad = 0;
    for (int i = 0; i < 24; i++)
      if (got_line[i] != q[i/4] || got_beat[i] != 2'(i % 4)) bad++;
    chk(bad == 0, "R9", "in-order return", bad, 0);
    chk(got_t[4] - got_t[3] == 8, "R11", "queued hit after last beat", got_t[4] - got_t[3], 8);
    chk(got_t[3] - got_t[0] == 3 && got_t[23] - got_t[20] == 3, "R5", "beats back to back",
        got_t[3] - got_t[0], 3);
  endtask

  always @(posedge clk) begin
    if (!done && cyc > 20000) begin
      total++;
      fails++;
      $display("FAIL watchdog (R1..all): cycle %0d expected completion before 20000", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_interleave();
    t_reset_clears();
    t_single();
    t_queue();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule